// File: doc/BRIEF.md
# Static Seven-Segment LCD Driver for a 3½-Digit Reading

This block turns a finished measurement result into drive signals for a directly driven (non-multiplexed) liquid-crystal panel. The panel shows three full decimal digits, a leading half digit that can show only a "1", and a minus sign. Each result field is captured into a holding register by a one-cycle strobe from the conversion controller. The panel therefore keeps a steady value while the next conversion runs.

A free-running divider derives the panel's common electrode (backplane) signal from the system clock. The backplane is a symmetric square wave whose period is a parameterised number of clocks. Each segment output carries the same square wave. A segment that must be visible is inverted against the backplane, and a dark segment follows it. This keeps the average DC voltage across every segment near zero.

An overrange flag blanks the three full digits and leaves only the leading "1". A lamp-test input lights the whole panel ("1888" with the sign). In lamp test the segment outputs stop alternating and sit at a steady high level.

Top module: `lcd_static_drv`

## Requirements
- R1: `bp_out` is a square wave with a period of DIV_RATIO clocks (default 800): it is low for the first DIV_RATIO/2 clocks after reset, then high for DIV_RATIO/2, and so on.
- R2: Outside lamp test, every segment output equals `bp_out` when the segment is dark and equals its complement when the segment is lit, so it toggles at the backplane rate.
- R3: Each full digit i (units at i=0) uses the BCD nibble `bcd_in[4i+3:4i]` and drives `seg_out[7i+6:7i]`, with bit 0 = segment a through bit 6 = segment g in the usual a-top, clockwise, g-middle layout. Codes 0 to 9 light their standard shapes (1 lights b and c, 7 lights a, b and c, 6 and 9 include the tail). Codes 10 to 15 light nothing.
- R4: Both bits of `half_seg` (segments b and c of the leading position) are lit exactly when the captured thousands bit is 1.
- R5: `sign_seg` is lit exactly when the captured negative flag is 1.
- R6: Result inputs are captured only in a cycle where `load` is 1. At other times, changes on them have no effect on any output. A capture at clock edge k shows at the outputs after edge k+1.
- R7: When the captured overrange flag is 1, all three full digits are dark and the half digit is lit, whatever the captured digits and thousands bit are. The sign still follows R5.
- R8: While `lamp_test` is 1, from the next clock edge on, every output of `seg_out`, `half_seg` and `sign_seg` is held at a constant 1 regardless of the backplane. The backplane keeps running per R1.
- R9: After synchronous reset (`rst` = 1), all segment outputs and `bp_out` are 0 and the captured result is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | One-cycle strobe that captures the result inputs |
| bcd_in | input | 12 | Three BCD digits, units in the low nibble |
| thou_in | input | 1 | Leading half-digit "1" |
| neg_in | input | 1 | Result is negative |
| ovr_in | input | 1 | Result is out of range |
| lamp_test | input | 1 | Light all segments with steady levels |
| seg_out | output | 21 | Full-digit segment drives, 7 per digit |
| half_seg | output | 2 | Half-digit segments b and c |
| sign_seg | output | 1 | Minus-sign segment drive |
| bp_out | output | 1 | Backplane square wave |

## Verification
A wrong divider count moves the backplane edge away from the expected multiple of DIV_RATIO/2. The segment outputs move with it, so the fault shows on the first misplaced toggle, within at most one half period. A corrupted holding register or decoder shows as a wrong phase on some segment in the very next cycle, because every segment is compared against the backplane on every clock. Lamp-test and overrange errors show within one cycle of entering the mode. Lamp test is held across several backplane toggles so that any leftover alternation is caught.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;
  localparam int BCD_W = 4;
  localparam int SEG_W = 7;

  // bit 0 = a ... bit 6 = g; non-decimal codes stay dark
  function automatic logic [SEG_W-1:0] bcd_to_seg(input logic [BCD_W-1:0] v);
    logic [SEG_W-1:0] s;
    case (v)
      4'd0: s = 7'h3F;
      4'd1: s = 7'h06;
      4'd2: s = 7'h5B;
      4'd3: s = 7'h4F;
      4'd4: s = 7'h66;
      4'd5: s = 7'h6D;
      4'd6: s = 7'h7D;
      4'd7: s = 7'h07;
      4'd8: s = 7'h7F;
      4'd9: s = 7'h6F;
      default: s = '0;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/bp_divider.sv
module bp_divider #(
  parameter int DIV_RATIO = 800
) (
  input  logic clk,
  input  logic rst,
  output logic bp_nxt,
  output logic bp_q
);
  localparam int HALF = DIV_RATIO / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap   = (cnt == LAST);
  assign bp_nxt = bp_q ^ wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      bp_q <= 1'b0;
    end else begin
      cnt  <= wrap ? '0 : cnt + 1'b1;
      bp_q <= bp_nxt;
    end
  end

  AST_BP_STEADY: assert property (@(posedge clk) disable iff (rst)
    (cnt != LAST) |=> $stable(bp_q)); // R1
  AST_BP_FLIP: assert property (@(posedge clk) disable iff (rst)
    (cnt == LAST) |=> (bp_q != $past(bp_q))); // R1
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST); // R1
endmodule

// File: rtl/result_latch.sv
module result_latch #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= d;
  end

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(q)); // R6
endmodule

// File: rtl/seg_decoder.sv
module seg_decoder
  import lcd_drv_pkg::*;
(
  input  logic [BCD_W-1:0] bcd,
  input  logic             blank,
  output logic [SEG_W-1:0] seg_on
);
  always_comb begin
    seg_on = blank ? '0 : bcd_to_seg(bcd);
  end
endmodule

// File: rtl/lcd_static_drv.sv
module lcd_static_drv
  import lcd_drv_pkg::*;
#(
  parameter int NUM_DIGITS = 3,
  parameter int DIV_RATIO  = 800
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        load,
  input  logic [NUM_DIGITS*BCD_W-1:0] bcd_in,
  input  logic                        thou_in,
  input  logic                        neg_in,
  input  logic                        ovr_in,
  input  logic                        lamp_test,
  output logic [NUM_DIGITS*SEG_W-1:0] seg_out,
  output logic [1:0]                  half_seg,
  output logic                        sign_seg,
  output logic                        bp_out
);
  localparam int DIG_BITS = NUM_DIGITS * BCD_W;
  localparam int LAT_W    = DIG_BITS + 3;
  localparam int DSEG     = NUM_DIGITS * SEG_W;
  localparam int TOT      = DSEG + 3;

  logic [LAT_W-1:0] lat_q;
  logic [DIG_BITS-1:0] lat_bcd;
  logic lat_thou, lat_neg, lat_ovr;
  logic bp_nxt, bp_q;
  logic [DSEG-1:0] dig_on;
  logic [TOT-1:0]  on_vec;
  logic [TOT-1:0]  out_q;
  logic            chk_ok;

  result_latch #(.W(LAT_W)) u_latch (
    .clk (clk),
    .rst (rst),
    .load(load),
    .d   ({ovr_in, neg_in, thou_in, bcd_in}),
    .q   (lat_q)
  );

  assign {lat_ovr, lat_neg, lat_thou, lat_bcd} = lat_q;

  bp_divider #(.DIV_RATIO(DIV_RATIO)) u_div (
    .clk   (clk),
    .rst   (rst),
    .bp_nxt(bp_nxt),
    .bp_q  (bp_q)
  );

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
    seg_decoder u_dec (
      .bcd   (lat_bcd[i*BCD_W +: BCD_W]),
      .blank (lat_ovr),
      .seg_on(dig_on[i*SEG_W +: SEG_W])
    );
  end

  assign on_vec = {lat_neg, {2{lat_thou | lat_ovr}}, dig_on};

  always_ff @(posedge clk) begin
    if (rst)            out_q <= '0;
    else if (lamp_test) out_q <= '1;
    else                out_q <= on_vec ^ {TOT{bp_nxt}};
  end

  always_ff @(posedge clk) begin
    if (rst) chk_ok <= 1'b0;
    else     chk_ok <= 1'b1;
  end

  assign seg_out  = out_q[DSEG-1:0];
  assign half_seg = out_q[DSEG +: 2];
  assign sign_seg = out_q[TOT-1];
  assign bp_out   = bp_q;

  AST_SIGN_PHASE: assert property (@(posedge clk) disable iff (rst)
    (chk_ok && !$past(lamp_test)) |-> (sign_seg == (bp_out ^ $past(lat_neg)))); // R5
  AST_LAMP_STEADY: assert property (@(posedge clk) disable iff (rst)
    (chk_ok && $past(lamp_test)) |-> ((&seg_out) && (&half_seg) && sign_seg)); // R8
  AST_OVR_BLANK: assert property (@(posedge clk) disable iff (rst)
    (chk_ok && !$past(lamp_test) && $past(lat_ovr))
      |-> (seg_out == {DSEG{bp_out}} && half_seg == {2{!bp_out}})); // R7
  AST_RESET_DARK: assert property (@(posedge clk)
    $past(rst) |-> (out_q == '0 && !bp_out)); // R9
endmodule

// File: tb/lcd_static_drv_test.sv
module lcd_static_drv_test;
  localparam int CLK_PERIOD = 10;
  localparam int ND = 3;
  localparam int DIV = 800;
  localparam int HALF = DIV / 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load = 1'b0;
  logic [ND*4-1:0] bcd_in = '0;
  logic thou_in = 1'b0, neg_in = 1'b0, ovr_in = 1'b0, lamp_test = 1'b0;
  logic [ND*7-1:0] seg_out;
  logic [1:0] half_seg;
  logic sign_seg, bp_out;

  int n_cmp = 0;
  int n_bad = 0;
  bit started = 0;
  bit done = 0;
  string phase = "R9";

  // reference model state
  int m_edges = 0;
  logic [ND*4-1:0] m_bcd = '0;
  logic m_thou = 0, m_neg = 0, m_ovr = 0;
  logic [ND*7-1:0] e_dig = '0;
  logic [1:0] e_half = '0;
  logic e_sign = 0, e_bp = 0;

  lcd_static_drv #(.NUM_DIGITS(ND), .DIV_RATIO(DIV)) uut (
    .clk(clk), .rst(rst), .load(load), .bcd_in(bcd_in), .thou_in(thou_in),
    .neg_in(neg_in), .ovr_in(ovr_in), .lamp_test(lamp_test),
    .seg_out(seg_out), .half_seg(half_seg), .sign_seg(sign_seg), .bp_out(bp_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [6:0] shape(input int v);
    case (v)
      0: return 7'b0111111;
      1: return 7'b0000110;
      2: return 7'b1011011;
      3: return 7'b1001111;
      4: return 7'b1100110;
      5: return 7'b1101101;
      6: return 7'b1111101;
      7: return 7'b0000111;
      8: return 7'b1111111;
      9: return 7'b1101111;
      default: return 7'b0000000;
    endcase
  endfunction

  always @(posedge clk) begin
    started <= 1;
    if (rst) begin
      m_edges = 0;
      m_bcd = '0; m_thou = 0; m_neg = 0; m_ovr = 0;
      e_dig = '0; e_half = '0; e_sign = 0; e_bp = 0;
    end else begin
      m_edges = m_edges + 1;
      e_bp = ((m_edges / HALF) % 2) == 1;
      if (lamp_test) begin
        e_dig = '1; e_half = 2'b11; e_sign = 1;
      end else begin
        for (int k = 0; k < ND; k++)
          e_dig[k*7 +: 7] = (m_ovr ? 7'b0 : shape(int'(m_bcd[k*4 +: 4]))) ^ {7{e_bp}};
        e_half = {2{(m_thou | m_ovr) ^ e_bp}};
        e_sign = m_neg ^ e_bp;
      end
      if (load) begin
        m_bcd = bcd_in; m_thou = thou_in; m_neg = neg_in; m_ovr = ovr_in;
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s [%s] t=%0t got=%h expected=%h", tag, phase, $time, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      check("R1 backplane", 32'(bp_out), 32'(e_bp));
      check("R2 R3 digits", 32'(seg_out), 32'(e_dig));
      check("R4 half digit", 32'(half_seg), 32'(e_half));
      check("R5 sign", 32'(sign_seg), 32'(e_sign));
    end
  end

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // capture one result, then scramble the inputs without a strobe (R6)
  task automatic put(input logic [ND*4-1:0] d, input logic t, input logic n,
                     input logic o, input int hold);
    @(negedge clk);
    bcd_in = d; thou_in = t; neg_in = n; ovr_in = o; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    bcd_in = ~d; thou_in = ~t; neg_in = ~n; ovr_in = 1'b0;
    repeat (hold) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    phase = "R9";
    check("R9 reset segs", 32'({sign_seg, half_seg, seg_out}), 32'h0);
    check("R9 reset bp", 32'(bp_out), 32'h0);
    rst = 1'b0;
    phase = "R2 R3 R4 R5 R6";
    for (int i = 0; i < 16; i++)
      put({4'(i), 4'((i + 3) % 16), 4'((i + 7) % 16)}, i[0], i[1], 1'b0, 130);
    phase = "R6";
    @(negedge clk);
    bcd_in = 12'h999; neg_in = 1'b1; thou_in = 1'b1;
    repeat (300) @(negedge clk);
    phase = "R7";
    put(12'h456, 1'b0, 1'b1, 1'b1, 450);
    put(12'h123, 1'b1, 1'b0, 1'b1, 200);
    phase = "R8";
    @(negedge clk);
    lamp_test = 1'b1;
    repeat (900) @(negedge clk);
    lamp_test = 1'b0;
    phase = "R1 R2";
    put(12'h000, 1'b0, 1'b0, 1'b0, 1700);
    phase = "R9";
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 reset again", 32'({bp_out, sign_seg, half_seg, seg_out}), 32'h0);
    rst = 1'b0;
    phase = "R6 after reset";
    repeat (20) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not end, got=hung expected=finished");
      finish_run();
    end
  end
endmodule